// File: doc/BRIEF.md
# Clock Source Failover Controller

This block picks which of three clock sources drives the system: the always-present internal oscillator, an external oscillator, or a PLL fed from that external oscillator. It comes out of reset on the internal source. Software asks for a different source with a valid/ready request. The block then moves the one-hot gate enables over without a glitch. It first waits until the outgoing clock is sampled low and turns that clock's gate off. It then holds every gate closed for a short gap, and only after that opens the new gate. The block runs on the internal reference clock. The external and PLL clocks come in as raw signals and pass through synchronisers so their levels can be observed.

While the active source is external-based and the monitor is armed, a counter on the reference clock measures how long it has been since the last external edge. Rising and falling edges both count. If 16 reference cycles pass with no edge, the block declares a failure. It drops any external or PLL selection and returns to the internal source. It also sets a sticky interrupt flag and disarms the monitor. Software clears the flag with a pulse and re-arms the monitor with another pulse.

The request channel follows valid/ready rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no switch is in progress, so a request raised during a switch waits until the switch is over. The requester must hold `req_valid` and `req_src` steady until the request is taken. A request that is taken but cannot be met is dropped without effect.

Top module: `clk_fo_ctrl`

## Requirements
- R1: After reset, `src_sel` is 0 (internal), only `en_int` is high, `fail_irq` is low and `busy` is low.
- R2: A taken request with `req_src`=1 while `ext_ready` is high ends with `src_sel`=1 and only `en_ext` high.
- R3: A taken request with `req_src`=2 while `pll_lock` is high ends with `src_sel`=2 and only `en_pll` high.
- R4: A taken request for code 1 while `ext_ready` is low, for code 2 while `pll_lock` is low, for code 3, or for the source already active, leaves `src_sel`, the enables and `busy` unchanged.
- R5: `req_ready` is high exactly when `busy` is low. A request held while busy is taken only once the switch has finished.
- R6: At most one enable is high in any cycle. An enable rises only after a cycle in which all enables were low.
- R7: Outside a failure, `en_ext` or `en_pll` falls only after a cycle in which that clock was sampled low.
- R8: With the monitor armed and source 1 or 2 active, a gap of 16 reference cycles without an external edge sets `fail_irq`, drops the external-based enable, and returns to `src_sel`=0. A clock that keeps toggling never causes a failure.
- R9: A failure while the PLL is active drops the PLL selection along with the external one.
- R10: `fail_irq` stays high until a `fail_clr` pulse clears it.
- R11: A failure disarms the monitor. A stopped external clock then causes no fallback until a `mon_arm` pulse re-arms it.
- R12: While the internal source is active, a stopped external clock has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Internal reference clock, runs the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Raw external oscillator clock |
| pll_clk | input | 1 | Raw PLL output clock |
| ext_ready | input | 1 | External oscillator stable |
| pll_lock | input | 1 | PLL locked |
| req_valid | input | 1 | Source switch request valid |
| req_src | input | 2 | Requested source: 0 internal, 1 external, 2 PLL |
| req_ready | output | 1 | Request can be taken |
| mon_arm | input | 1 | Pulse: re-arm the failure monitor |
| fail_clr | input | 1 | Pulse: clear the failure flag |
| en_int | output | 1 | Gate enable for internal clock |
| en_ext | output | 1 | Gate enable for external clock |
| en_pll | output | 1 | Gate enable for PLL clock |
| src_sel | output | 2 | Active source code |
| busy | output | 1 | Switch in progress |
| fail_irq | output | 1 | Sticky external-clock failure interrupt |

## Verification
The bound checker checks the following in every cycle: the enables are one-hot-or-zero with a closed gap before any enable opens, an outgoing external or PLL gate closes only at a sampled low level, the failure flag is sticky, a failure occurs only with the monitor armed, and a refused request changes nothing. Other properties depend on stopping and restarting the external clock, so only the directed scenarios show them. These are the 16-cycle detection window and its no-early-trip side, fallback from the PLL, the monitor staying disarmed after a failure, and a stopped clock being harmless while the internal source is active.

// File: rtl/clk_fo_pkg.sv
package clk_fo_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_GAP   = 2'd2
  } sw_state_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/clk_fo_sync.sv
module clk_fo_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_fo_mon.sv
module clk_fo_mon #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic armed,
  output logic fail_det
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic          prev;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  assign edge_seen = lvl ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!armed || edge_seen) cnt <= '0;
    else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
  end

  assign fail_det = armed && !edge_seen && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/clk_fo_sel.sv
module clk_fo_sel
  import clk_fo_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_src,
  output logic               req_ready,
  input  logic               ext_ready,
  input  logic               pll_lock,
  input  logic               ext_lvl,
  input  logic               pll_lvl,
  input  logic               fail_det,
  output logic [1:0]         cur_src,
  output logic               busy,
  output logic [NUM_SRC-1:0] en
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  sw_state_e     state;
  src_e          cur;
  src_e          tgt;
  logic [GW-1:0] gcnt;
  logic          legal;
  logic          old_low;
  logic          take;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;

  always_comb begin
    case (req_src)
      2'd0:    legal = 1'b1;
      2'd1:    legal = ext_ready;
      2'd2:    legal = pll_lock;
      default: legal = 1'b0;
    endcase
    if (req_src == cur) legal = 1'b0;
  end

  always_comb begin
    case (cur)
      SRC_EXT: old_low = !ext_lvl;
      SRC_PLL: old_low = !pll_lvl;
      default: old_low = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= SRC_INT;
      tgt   <= SRC_INT;
      gcnt  <= '0;
    end else if (fail_det) begin
      state <= ST_GAP;
      tgt   <= SRC_INT;
      gcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take && legal) begin
            state <= ST_DRAIN;
            tgt   <= src_e'(req_src);
          end
        end
        ST_DRAIN: begin
          if (old_low) begin
            state <= ST_GAP;
            gcnt  <= '0;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            cur   <= tgt;
            state <= ST_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_en
      assign en[s] = (state != ST_GAP) && (cur == src_e'(s));
    end
  endgenerate

  assign cur_src = cur;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/clk_fo_ctrl.sv
module clk_fo_ctrl
  import clk_fo_pkg::*;
#(
  parameter int LIMIT   = 16,
  parameter int GAP_CYC = 2,
  parameter int SYNC_N  = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       pll_clk,
  input  logic       ext_ready,
  input  logic       pll_lock,
  input  logic       req_valid,
  input  logic [1:0] req_src,
  output logic       req_ready,
  input  logic       mon_arm,
  input  logic       fail_clr,
  output logic       en_int,
  output logic       en_ext,
  output logic       en_pll,
  output logic [1:0] src_sel,
  output logic       busy,
  output logic       fail_irq
);
  logic [1:0]         lvl_s;
  logic               ext_s;
  logic               pll_s;
  logic               mon_en;
  logic               armed;
  logic               fail_det;
  logic [NUM_SRC-1:0] en;
  logic               gap_now;

  clk_fo_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     ({pll_clk, ext_clk}),
    .q     (lvl_s)
  );
  assign ext_s = lvl_s[0];
  assign pll_s = lvl_s[1];

  assign gap_now = busy && (en == '0);
  assign armed   = mon_en && !gap_now &&
                   ((src_sel == SRC_EXT) || (src_sel == SRC_PLL));

  clk_fo_mon #(.LIMIT(LIMIT)) u_mon (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .lvl      (ext_s),
    .armed    (armed),
    .fail_det (fail_det)
  );

  clk_fo_sel #(.GAP_CYC(GAP_CYC)) u_sel (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_ready (req_ready),
    .ext_ready (ext_ready),
    .pll_lock  (pll_lock),
    .ext_lvl   (ext_s),
    .pll_lvl   (pll_s),
    .fail_det  (fail_det),
    .cur_src   (src_sel),
    .busy      (busy),
    .en        (en)
  );

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      fail_irq <= 1'b0;
      mon_en   <= 1'b1;
    end else begin
      if (fail_det)      fail_irq <= 1'b1;
      else if (fail_clr) fail_irq <= 1'b0;
      if (fail_det)      mon_en <= 1'b0;
      else if (mon_arm)  mon_en <= 1'b1;
    end
  end

  assign en_int = en[SRC_INT];
  assign en_ext = en[SRC_EXT];
  assign en_pll = en[SRC_PLL];
endmodule

// File: rtl/clk_fo_ctrl_chk.sv
module clk_fo_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_int,
  input logic       en_ext,
  input logic       en_pll,
  input logic       ext_lvl,
  input logic       pll_lvl,
  input logic       fail_irq,
  input logic       fail_clr,
  input logic       mon_en,
  input logic       busy,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_src,
  input logic       ext_ready,
  input logic       pll_lock,
  input logic [1:0] src_sel
);
  logic [2:0] ens;
  assign ens = {en_pll, en_ext, en_int};

  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ens)); // R6
  AST_GAP_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_int) || $rose(en_ext) || $rose(en_pll)) |-> ($past(ens) == 3'b000)); // R6
  AST_EXT_LOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_ext) |-> (!$past(ext_lvl) || $rose(fail_irq))); // R7
  AST_PLL_LOW_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_pll) |-> (!$past(pll_lvl) || $rose(fail_irq))); // R7
  AST_FAIL_DROPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_irq) |-> (!en_ext && !en_pll && busy)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_irq && !fail_clr) |=> fail_irq); // R10
  AST_FAIL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_irq) |-> $past(mon_en)); // R11
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy); // R5
  AST_REFUSE_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src == 2'd1 && !ext_ready) |=>
      ((!busy && $stable(src_sel)) || $rose(fail_irq))); // R4
  AST_REFUSE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_src == 2'd2 && !pll_lock) |=>
      ((!busy && $stable(src_sel)) || $rose(fail_irq))); // R4
endmodule

bind clk_fo_ctrl clk_fo_ctrl_chk u_chk (
  .clk       (clk_ref),
  .rst_n     (rst_n),
  .en_int    (en_int),
  .en_ext    (en_ext),
  .en_pll    (en_pll),
  .ext_lvl   (ext_s),
  .pll_lvl   (pll_s),
  .fail_irq  (fail_irq),
  .fail_clr  (fail_clr),
  .mon_en    (mon_en),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .ext_ready (ext_ready),
  .pll_lock  (pll_lock),
  .src_sel   (src_sel)
);

// File: tb/clk_fo_ctrl_test.sv
`timescale 1ns/1ps
module clk_fo_ctrl_test;
  logic       clk_ref = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       pll_clk = 1'b0;
  logic       ext_ready = 1'b0;
  logic       pll_lock = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_src = 2'd0;
  logic       req_ready;
  logic       mon_arm = 1'b0;
  logic       fail_clr = 1'b0;
  logic       en_int, en_ext, en_pll;
  logic [1:0] src_sel;
  logic       busy;
  logic       fail_irq;

  logic ext_run = 1'b1;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  clk_fo_ctrl uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .ext_clk(ext_clk), .pll_clk(pll_clk),
    .ext_ready(ext_ready), .pll_lock(pll_lock), .req_valid(req_valid),
    .req_src(req_src), .req_ready(req_ready), .mon_arm(mon_arm),
    .fail_clr(fail_clr), .en_int(en_int), .en_ext(en_ext), .en_pll(en_pll),
    .src_sel(src_sel), .busy(busy), .fail_irq(fail_irq)
  );

  always #10 clk_ref = ~clk_ref;
  always #7  pll_clk = ~pll_clk;
  initial forever begin
    #30;
    if (ext_run) ext_clk = ~ext_clk;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  task automatic send(input logic [1:0] s);
    @(negedge clk_ref);
    req_valid = 1'b1;
    req_src   = s;
    while (!req_ready) @(negedge clk_ref);
    @(negedge clk_ref);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk_ref);
  endtask

  task automatic pulse(input bit which);
    @(negedge clk_ref);
    if (which) mon_arm = 1'b1; else fail_clr = 1'b1;
    @(negedge clk_ref);
    mon_arm = 1'b0;
    fail_clr = 1'b0;
  endtask

  task automatic stop_ext;
    ext_run = 1'b0;
    ext_clk = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 src_sel", src_sel, 0);
    check("R1 enables", {en_pll, en_ext, en_int}, 3'b001);
    check("R1 fail_irq", fail_irq, 0);
    check("R1 busy", busy, 0);
  endtask

  task automatic t_refuse;
    send(2'd1);
    check("R4 ext not ready busy", busy, 0);
    check("R4 ext not ready src", src_sel, 0);
    send(2'd2);
    check("R4 pll not locked src", src_sel, 0);
    send(2'd3);
    check("R4 code 3 enables", {en_pll, en_ext, en_int}, 3'b001);
    send(2'd0);
    check("R4 same source busy", busy, 0);
  endtask

  task automatic t_to_ext;
    ext_ready = 1'b1;
    send(2'd1);
    check("R5 ready low while switching", req_ready, 0);
    wait_idle();
    check("R2 src ext", src_sel, 1);
    check("R2 enables", {en_pll, en_ext, en_int}, 3'b010);
    cycles(60);
    check("R8 running clock no fail", fail_irq, 0);
  endtask

  task automatic t_backpressure;
    pll_lock = 1'b1;
    send(2'd2);
    @(negedge clk_ref);
    req_valid = 1'b1;
    req_src   = 2'd0;
    check("R5 held request not taken", req_ready, 0);
    while (!req_ready) @(negedge clk_ref);
    check("R3 src pll", src_sel, 2);
    check("R3 enables", {en_pll, en_ext, en_int}, 3'b100);
    @(negedge clk_ref);
    req_valid = 1'b0;
    wait_idle();
    check("R5 held request served", src_sel, 0);
  endtask

  task automatic t_fail_pll;
    send(2'd2);
    wait_idle();
    check("R3 src pll again", src_sel, 2);
    stop_ext();
    cycles(8);
    check("R8 no early trip", fail_irq, 0);
    cycles(22);
    check("R8 flag set", fail_irq, 1);
    wait_idle();
    check("R9 pll abandoned src", src_sel, 0);
    check("R9 enables", {en_pll, en_ext, en_int}, 3'b001);
    cycles(5);
    check("R10 sticky", fail_irq, 1);
    pulse(1'b0);
    check("R10 cleared", fail_irq, 0);
  endtask

  task automatic t_disarmed;
    ext_run = 1'b1;
    send(2'd1);
    wait_idle();
    check("R2 back on ext", src_sel, 1);
    stop_ext();
    cycles(40);
    check("R11 disarmed no fallback src", src_sel, 1);
    check("R11 disarmed flag", fail_irq, 0);
    pulse(1'b1);
    cycles(30);
    check("R11 rearmed trips", fail_irq, 1);
    wait_idle();
    check("R8 fallback to int", src_sel, 0);
    check("R8 enables", {en_pll, en_ext, en_int}, 3'b001);
    pulse(1'b0);
    pulse(1'b1);
  endtask

  task automatic t_idle_int;
    cycles(40);
    check("R12 int unaffected flag", fail_irq, 0);
    check("R12 int unaffected src", src_sel, 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_refuse();
    t_to_ext();
    t_backpressure();
    t_fail_pll();
    t_disarmed();
    t_idle_int();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule